// File: doc/BRIEF.md
# Threshold-Gated Audio FIFO Channel

This block is a single buffer channel placed between a memory-side DMA master and an audio-side serial interface. It runs in one of two directions. In playback the DMA writes words into the buffer and the audio side takes them out over a valid/ready stream. That stream stays closed until the buffer holds a programmed number of words. Once it opens, it stays open until the buffer is empty, and then the threshold applies again. In capture the audio side pushes words in over a valid/ready stream, and the DMA reads them back with a one-cycle read latency. No threshold applies in capture.

The channel never tells the DMA that a fill level has been reached. Its only message to the DMA is a one-cycle event for every word that moves on the audio side. The DMA counts these events against its own copy of the buffer depth and decides when to move its next burst. Full, empty and a level count are exported. Two sticky flags record a write into a full buffer and a read request on an empty buffer.

Top module: `pcm_fifo_chan`

## Requirements
- R1: In the cycle after each audio-side word transfer, `word_event` is high for one cycle. An audio-side word transfer is a playback pop (`aud_out_valid` and `aud_out_ready` both high) or a capture push (`aud_in_valid` and `aud_in_ready` both high). In a cycle after no such transfer, `word_event` is low.
- R2: In playback (`cfg_capture` = 0), `aud_out_valid` stays low until the level reaches the effective threshold. The effective threshold is `cfg_threshold`, except that 0 counts as 1 and any value above DEPTH counts as DEPTH. Once the level reaches it, `aud_out_valid` rises in the cycle after the write that reached it.
- R3: In capture (`cfg_capture` = 1), no threshold applies. A `dma_rd_en` on a non-empty buffer returns the oldest word on `dma_rd_data`, with `dma_rd_valid` high, one cycle later. In capture, `aud_out_valid` stays low and `dma_wr_en` is ignored.
- R4: Once playback draining has started, it continues word by word even when the level falls below the threshold. When the buffer becomes empty, draining stops, and it starts again only when the level next reaches the effective threshold.
- R5: Words leave in the order they entered, including when a write and a read happen in the same cycle.
- R6: `level` counts the stored words. `full` is high exactly when `level` equals DEPTH, and `empty` is high exactly when `level` is 0.
- R7: A write attempt on a full buffer drops the word and sets `overrun`, which stays set until reset. A write attempt is `dma_wr_en` in playback or `aud_in_valid` in capture. In capture, `aud_in_ready` is low while the buffer is full.
- R8: `underrun` is set in two cases and stays set until reset. In playback, it is set when `aud_out_ready` is high, the buffer is empty and draining has started at least once since reset. In capture, it is set when `dma_rd_en` is high and the buffer is empty. A playback ready before the first start has no effect on it, and neither does a ready while the buffer is non-empty but below the threshold.
- R9: A synchronous `rst` empties the buffer, clears the draining and started state, and clears both sticky flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_capture | input | 1 | Direction: 0 playback, 1 capture |
| cfg_threshold | input | CW | Playback fill threshold in words |
| dma_wr_en | input | 1 | DMA write strobe (playback) |
| dma_wr_data | input | DATA_W | DMA write word |
| dma_rd_en | input | 1 | DMA read request (capture) |
| dma_rd_data | output | DATA_W | DMA read word, one cycle after request |
| dma_rd_valid | output | 1 | Marks `dma_rd_data` as a returned word |
| aud_in_valid | input | 1 | Audio-side push valid (capture) |
| aud_in_data | input | DATA_W | Audio-side push word |
| aud_in_ready | output | 1 | Channel accepts a push |
| aud_out_valid | output | 1 | Audio-side drain valid (playback) |
| aud_out_data | output | DATA_W | Oldest stored word |
| aud_out_ready | input | 1 | Audio side takes a word |
| word_event | output | 1 | One pulse per audio-side word moved |
| level | output | CW | Stored word count |
| full | output | 1 | Buffer full |
| empty | output | 1 | Buffer empty |
| overrun | output | 1 | Sticky write-on-full flag |
| underrun | output | 1 | Sticky read-on-empty flag |

## Verification
The bench builds the channel with DEPTH = 16 and 32-bit words, so `cfg_threshold` is five bits wide. This lets it sweep every threshold from 0 to 20 in full, including the zero case and the cases clamped to DEPTH. For each threshold it fills the buffer word by word, checks the first cycle in which draining may start, then drains to empty and checks the re-arm. The small depth keeps full and overrun, underrun, and the 16-word threshold reached by two 8-word bursts within a few dozen cycles per case.

// File: rtl/pcm_fifo_pkg.sv
package pcm_fifo_pkg;

  typedef enum logic {
    DIR_PLAYBACK = 1'b0,
    DIR_CAPTURE  = 1'b1
  } dir_e;

  // Effective playback threshold: zero behaves as one, large values saturate at the depth.
  function automatic int unsigned clamp_thr(input int unsigned thr, input int unsigned depth);
    if (thr == 0) return 1;
    else if (thr > depth) return depth;
    else return thr;
  endfunction

endpackage

// File: rtl/pcm_fifo_store.sv
module pcm_fifo_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     peek_addr,
  output logic [DATA_W-1:0] peek_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // Show-ahead port for the streaming side.
  assign peek_data = mem[peek_addr];

  // Registered port for the DMA side.
  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/pcm_fifo_ptrs.sv
module pcm_fifo_ptrs #(
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] level,
  output logic [CW-1:0] level_nxt,
  output logic          full,
  output logic          empty
);

  always_comb begin
    level_nxt = level + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      full   <= 1'b0;
      empty  <= 1'b1;
    end else begin
      if (push) wr_ptr <= wr_ptr + AW'(1);
      if (pop)  rd_ptr <= rd_ptr + AW'(1);
      level <= level_nxt;
      full  <= (level_nxt == CW'(DEPTH));
      empty <= (level_nxt == '0);
    end
  end

endmodule

// File: rtl/pcm_fifo_gate.sv
module pcm_fifo_gate
  import pcm_fifo_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  dir_e          dir,
  input  logic [CW-1:0] thr,
  input  logic [CW-1:0] level_nxt,
  output logic          draining,
  output logic          started
);

  logic [CW-1:0] thr_eff;
  logic          drain_nxt;

  always_comb begin
    thr_eff   = CW'(clamp_thr(32'(thr), DEPTH));
    drain_nxt = (dir == DIR_PLAYBACK) &&
                ((level_nxt >= thr_eff) || (draining && (level_nxt != '0)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      draining <= 1'b0;
      started  <= 1'b0;
    end else begin
      draining <= drain_nxt;
      if (drain_nxt) started <= 1'b1;
    end
  end

endmodule

// File: rtl/pcm_fifo_flags.sv
module pcm_fifo_flags (
  input  logic clk,
  input  logic rst,
  input  logic wr_drop,
  input  logic rd_starve,
  input  logic aud_move,
  output logic overrun,
  output logic underrun,
  output logic word_event
);

  always_ff @(posedge clk) begin
    if (rst) begin
      overrun    <= 1'b0;
      underrun   <= 1'b0;
      word_event <= 1'b0;
    end else begin
      if (wr_drop)   overrun  <= 1'b1;
      if (rd_starve) underrun <= 1'b1;
      word_event <= aud_move;
    end
  end

endmodule

// File: rtl/pcm_fifo_chan.sv
module pcm_fifo_chan
  import pcm_fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_capture,
  input  logic [CW-1:0]     cfg_threshold,
  input  logic              dma_wr_en,
  input  logic [DATA_W-1:0] dma_wr_data,
  input  logic              dma_rd_en,
  output logic [DATA_W-1:0] dma_rd_data,
  output logic              dma_rd_valid,
  input  logic              aud_in_valid,
  input  logic [DATA_W-1:0] aud_in_data,
  output logic              aud_in_ready,
  output logic              aud_out_valid,
  output logic [DATA_W-1:0] aud_out_data,
  input  logic              aud_out_ready,
  output logic              word_event,
  output logic [CW-1:0]     level,
  output logic              full,
  output logic              empty,
  output logic              overrun,
  output logic              underrun
);

  dir_e              dir;
  logic              wr_req, push, pop, pb_pop, cp_pop;
  logic [DATA_W-1:0] wr_word;
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     level_nxt;
  logic              draining, started;
  logic              wr_drop, rd_starve, aud_move;

  assign dir = cfg_capture ? DIR_CAPTURE : DIR_PLAYBACK;

  always_comb begin
    wr_req  = (dir == DIR_CAPTURE) ? aud_in_valid : dma_wr_en;
    wr_word = (dir == DIR_CAPTURE) ? aud_in_data  : dma_wr_data;
    push    = wr_req && !full;
    pb_pop  = (dir == DIR_PLAYBACK) && aud_out_valid && aud_out_ready;
    cp_pop  = (dir == DIR_CAPTURE)  && dma_rd_en && !empty;
    pop     = pb_pop || cp_pop;
    wr_drop = wr_req && full;
    rd_starve = (dir == DIR_PLAYBACK) ? (aud_out_ready && started && empty)
                                      : (dma_rd_en && empty);
    aud_move  = (dir == DIR_CAPTURE) ? push : pb_pop;
  end

  assign aud_in_ready  = (dir == DIR_CAPTURE) && !full;
  assign aud_out_valid = draining && !empty;

  pcm_fifo_ptrs #(.DEPTH(DEPTH)) ptrs_i (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .pop       (pop),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr),
    .level     (level),
    .level_nxt (level_nxt),
    .full      (full),
    .empty     (empty)
  );

  pcm_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
    .clk       (clk),
    .wr_en     (push),
    .wr_addr   (wr_ptr),
    .wr_data   (wr_word),
    .peek_addr (rd_ptr),
    .peek_data (aud_out_data),
    .rd_en     (cp_pop),
    .rd_addr   (rd_ptr),
    .rd_data   (dma_rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) dma_rd_valid <= 1'b0;
    else     dma_rd_valid <= cp_pop;
  end

  pcm_fifo_gate #(.DEPTH(DEPTH)) gate_i (
    .clk       (clk),
    .rst       (rst),
    .dir       (dir),
    .thr       (cfg_threshold),
    .level_nxt (level_nxt),
    .draining  (draining),
    .started   (started)
  );

  pcm_fifo_flags flags_i (
    .clk        (clk),
    .rst        (rst),
    .wr_drop    (wr_drop),
    .rd_starve  (rd_starve),
    .aud_move   (aud_move),
    .overrun    (overrun),
    .underrun   (underrun),
    .word_event (word_event)
  );

endmodule

// File: rtl/pcm_fifo_chan_chk.sv
module pcm_fifo_chan_chk
  import pcm_fifo_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_capture,
  input logic [CW-1:0] cfg_threshold,
  input logic          aud_in_valid,
  input logic          aud_in_ready,
  input logic          aud_out_valid,
  input logic          aud_out_ready,
  input logic          word_event,
  input logic [CW-1:0] level,
  input logic          full,
  input logic          empty,
  input logic          overrun,
  input logic          underrun
);

  logic          hs;
  logic [CW-1:0] thr_ref;

  always_comb begin
    hs      = cfg_capture ? (aud_in_valid && aud_in_ready) : (aud_out_valid && aud_out_ready);
    thr_ref = CW'(clamp_thr(32'(cfg_threshold), DEPTH));
  end

  p_event_after_word_r1: assert property (@(posedge clk) disable iff (rst)
    hs |=> word_event);

  p_no_event_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !hs |=> !word_event);

  p_open_at_threshold_r2: assert property (@(posedge clk) disable iff (rst)
    (!cfg_capture && $rose(aud_out_valid)) |-> (level >= thr_ref));

  p_capture_no_out_r3: assert property (@(posedge clk) disable iff (rst)
    cfg_capture |-> !aud_out_valid);

  p_level_bound_r6: assert property (@(posedge clk) disable iff (rst)
    (level <= CW'(DEPTH)) && !(full && empty));

  p_level_step_r6: assert property (@(posedge clk) disable iff (rst)
    (level == $past(level)) || (level == $past(level) + CW'(1)) || (level + CW'(1) == $past(level)));

  p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  p_underrun_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    underrun |=> underrun);

  p_reset_clears_r9: assert property (@(posedge clk)
    rst |=> (empty && !full && !overrun && !underrun && !aud_out_valid));

endmodule

bind pcm_fifo_chan pcm_fifo_chan_chk #(.DEPTH(DEPTH)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .cfg_capture   (cfg_capture),
  .cfg_threshold (cfg_threshold),
  .aud_in_valid  (aud_in_valid),
  .aud_in_ready  (aud_in_ready),
  .aud_out_valid (aud_out_valid),
  .aud_out_ready (aud_out_ready),
  .word_event    (word_event),
  .level         (level),
  .full          (full),
  .empty         (empty),
  .overrun       (overrun),
  .underrun      (underrun)
);

// File: tb/pcm_fifo_chan_tb_top.sv
module pcm_fifo_chan_tb_top;

  localparam int DATA_W = 32;
  localparam int DEPTH  = 16;
  localparam int CW     = $clog2(DEPTH) + 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_capture = 1'b0;
  logic [CW-1:0]     cfg_threshold = '0;
  logic              dma_wr_en = 1'b0;
  logic [DATA_W-1:0] dma_wr_data = '0;
  logic              dma_rd_en = 1'b0;
  logic [DATA_W-1:0] dma_rd_data;
  logic              dma_rd_valid;
  logic              aud_in_valid = 1'b0;
  logic [DATA_W-1:0] aud_in_data = '0;
  logic              aud_in_ready;
  logic              aud_out_valid;
  logic [DATA_W-1:0] aud_out_data;
  logic              aud_out_ready = 1'b0;
  logic              word_event;
  logic [CW-1:0]     level;
  logic              full, empty, overrun, underrun;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  pcm_fifo_chan #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .cfg_capture(cfg_capture), .cfg_threshold(cfg_threshold),
    .dma_wr_en(dma_wr_en), .dma_wr_data(dma_wr_data),
    .dma_rd_en(dma_rd_en), .dma_rd_data(dma_rd_data), .dma_rd_valid(dma_rd_valid),
    .aud_in_valid(aud_in_valid), .aud_in_data(aud_in_data), .aud_in_ready(aud_in_ready),
    .aud_out_valid(aud_out_valid), .aud_out_data(aud_out_data), .aud_out_ready(aud_out_ready),
    .word_event(word_event), .level(level), .full(full), .empty(empty),
    .overrun(overrun), .underrun(underrun)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic capt, input int thr);
    rst = 1'b1;
    cfg_capture = capt;
    cfg_threshold = CW'(thr);
    dma_wr_en = 0; dma_rd_en = 0; aud_in_valid = 0; aud_out_ready = 0;
    repeat (3) step();
    rst = 1'b0;
  endtask

  task automatic dma_write(input logic [31:0] w);
    dma_wr_en = 1'b1; dma_wr_data = w;
    step();
    dma_wr_en = 1'b0;
  endtask

  initial begin
    @(negedge clk);

    // Reset state (R9, R6)
    do_reset(1'b0, 4);
    chk("R9 reset empty", 32'(empty), 1);
    chk("R9 reset full", 32'(full), 0);
    chk("R9 reset level", 32'(level), 0);
    chk("R9 reset flags", {30'd0, overrun, underrun}, 0);

    // Ready before any start leaves underrun clear (R8)
    aud_out_ready = 1'b1;
    repeat (3) step();
    chk("R8 no underrun before start", 32'(underrun), 0);
    chk("R1 no event while idle", 32'(word_event), 0);
    aud_out_ready = 1'b0;

    // Threshold sweep in playback (R2, R4, R5, R6, R7, R8, R1)
    for (int t = 0; t <= 20; t++) begin
      int te;
      logic [31:0] base;
      te = (t == 0) ? 1 : ((t > DEPTH) ? DEPTH : t);
      base = 32'hA000_0000 + 32'(t) * 32'h100;
      do_reset(1'b0, t);
      for (int k = 1; k <= DEPTH; k++) begin
        dma_write(base + 32'(k - 1));
        chk($sformatf("R2 gate t=%0d k=%0d", t, k), 32'(aud_out_valid), 32'(k >= te));
        chk("R6 level", 32'(level), 32'(k));
      end
      chk("R6 full", 32'(full), 1);
      dma_write(32'hDEAD_BEEF);
      chk("R7 overrun on full", 32'(overrun), 1);
      chk("R7 level unchanged", 32'(level), DEPTH);
      aud_out_ready = 1'b1;
      for (int k = 0; k < DEPTH; k++) begin
        chk("R4 drain continues", 32'(aud_out_valid), 1);
        chk("R5 order", aud_out_data, base + 32'(k));
        step();
        chk("R1 event per pop", 32'(word_event), 1);
      end
      chk("R6 empty after drain", 32'(empty), 1);
      chk("R4 stop at empty", 32'(aud_out_valid), 0);
      chk("R8 not yet underrun", 32'(underrun), 0);
      step();
      chk("R8 underrun after start", 32'(underrun), 1);
      chk("R1 no event on empty", 32'(word_event), 0);
      // Re-arm: below threshold nothing drains even with ready high
      for (int k = 1; k < te; k++) begin
        dma_write(base + 32'h80 + 32'(k));
        chk("R4 re-armed gate", 32'(aud_out_valid), 0);
        step();
        chk("R1 no event while gated", 32'(word_event), 0);
      end
      dma_write(base + 32'hFF);
      chk("R4 reopens at threshold", 32'(aud_out_valid), 1);
      aud_out_ready = 1'b0;
    end

    // Two 8-word bursts needed for a 16-word threshold (R2)
    do_reset(1'b0, 16);
    for (int k = 0; k < 8; k++) dma_write(32'h100 + 32'(k));
    chk("R2 first burst not enough", 32'(aud_out_valid), 0);
    for (int k = 8; k < 16; k++) dma_write(32'h100 + 32'(k));
    chk("R2 second burst opens", 32'(aud_out_valid), 1);

    // Concurrent write and pop keep order and level (R5)
    do_reset(1'b0, 2);
    dma_write(32'h500);
    dma_write(32'h501);
    aud_out_ready = 1'b1;
    for (int k = 0; k < 6; k++) begin
      chk("R5 concurrent order", aud_out_data, 32'h500 + 32'(k));
      dma_wr_en = 1'b1; dma_wr_data = 32'h502 + 32'(k);
      step();
      chk("R5 concurrent level", 32'(level), 2);
    end
    dma_wr_en = 1'b0;
    aud_out_ready = 1'b0;

    // Capture direction (R3, R1, R7, R8)
    do_reset(1'b1, 31);
    chk("R3 capture ready", 32'(aud_in_ready), 1);
    aud_in_valid = 1'b1; aud_in_data = 32'hC000;
    step();
    aud_in_valid = 1'b0;
    chk("R1 event on push", 32'(word_event), 1);
    chk("R3 no stream out", 32'(aud_out_valid), 0);
    dma_wr_en = 1'b1; dma_wr_data = 32'hBAD;
    step();
    dma_wr_en = 1'b0;
    chk("R3 dma write ignored", 32'(level), 1);
    chk("R1 no event on idle", 32'(word_event), 0);
    dma_rd_en = 1'b1;
    step();
    dma_rd_en = 1'b0;
    chk("R3 read valid", 32'(dma_rd_valid), 1);
    chk("R3 read data", dma_rd_data, 32'hC000);
    chk("R1 no event on dma read", 32'(word_event), 0);
    for (int k = 0; k < DEPTH; k++) begin
      aud_in_valid = 1'b1; aud_in_data = 32'hC100 + 32'(k);
      step();
    end
    chk("R6 capture full", 32'(full), 1);
    chk("R7 ready low when full", 32'(aud_in_ready), 0);
    chk("R7 no overrun yet", 32'(overrun), 0);
    step();
    aud_in_valid = 1'b0;
    chk("R7 overrun on push", 32'(overrun), 1);
    chk("R1 no event on drop", 32'(word_event), 0);
    for (int k = 0; k < DEPTH; k++) begin
      dma_rd_en = 1'b1;
      step();
      chk("R3 read valid seq", 32'(dma_rd_valid), 1);
      chk("R5 capture order", dma_rd_data, 32'hC100 + 32'(k));
    end
    chk("R8 no underrun yet", 32'(underrun), 0);
    step();
    dma_rd_en = 1'b0;
    chk("R8 capture underrun", 32'(underrun), 1);
    chk("R3 no data on empty", 32'(dma_rd_valid), 0);

    // Reset clears sticky flags (R9)
    do_reset(1'b1, 0);
    chk("R9 flags cleared", {30'd0, overrun, underrun}, 0);
    chk("R9 level cleared", 32'(level), 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule